// File: doc/BRIEF.md
# Cache Line Fill Qualifier

This block sits beside the bus unit of a processor and decides, for each read cycle it sees start, whether that cycle turns into a cache line fill. A read becomes a fill only when the cycle is internally cacheable, is not locked, and the active-low external cache-enable input is low on the clock where the cycle starts. During a fill, the block counts the ready strobes of the line's transfers. On the last one it emits exactly one verdict pulse to the cache array: commit when the line may be written, or discard when it may not.

The external enable is looked at a second time, in the clock just before the final ready. That later sample alone decides between commit and discard. The enable level in the final ready clock itself plays no part. A fill whose late sample is inactive still runs all of its transfers and ends with a discard pulse.

The block also produces the page-cache-disable output for the cycle. It chooses the page entry bit for paged cycles and the control register bit otherwise, forces the result low when the cache-disable control bit is set, and holds it for the whole cycle.

Top module: `line_fill_qual`

## Requirements
- R1: After reset, fill_active, commit and discard are 0, xfer_idx is 0 and pcd_out is 0.
- R2: When cyc_start is high with cyc_read=1, cyc_cacheable=1, cyc_locked=0 and cen_n=0 (enable active low), fill_active is 1 from the following clock.
- R3: A started cycle with cen_n=1, with cyc_cacheable=0, or with cyc_read=0 does not become a fill: fill_active stays 0.
- R4: A started cycle with cyc_locked=1 never becomes a fill, even with cen_n=0.
- R5: During a fill, each clock with rdy=1 advances xfer_idx by one, from 0 up to 3 for a 16-byte line of 4-byte transfers. Clocks with rdy=0 leave it unchanged.
- R6: The ready taken while xfer_idx is 3 is the last one. fill_active is 0 from the next clock and xfer_idx returns to 0.
- R7: If cen_n was 0 in the clock just before the last ready's clock, commit is 1 for exactly the one clock after the last ready. The cen_n level in the last ready's own clock has no effect.
- R8: If cen_n was 1 in that earlier clock, discard pulses for one clock instead. commit and discard are never 1 together.
- R9: A cyc_start during a fill abandons it: xfer_idx returns to 0, the new cycle is qualified afresh, and the abandoned fill yields neither commit nor discard.
- R10: On cyc_start, pcd_out takes pte_pcd when paging_en=1 and cyc_paged=1, and takes cr_pcd otherwise. It holds that value until the next cyc_start.
- R11: When cr_cd=1 at cyc_start, pcd_out is 0 for that cycle, whatever the selected bit.
- R12: A ready outside a fill is ignored: xfer_idx stays 0 and no commit or discard pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_start | input | 1 | First clock of a new bus cycle |
| cyc_read | input | 1 | Started cycle is a read |
| cyc_cacheable | input | 1 | Started cycle is internally cacheable |
| cyc_locked | input | 1 | Started cycle is locked |
| cyc_paged | input | 1 | Started cycle went through page translation |
| paging_en | input | 1 | Paging is enabled |
| pte_pcd | input | 1 | Cache-disable bit from the page entry |
| cr_pcd | input | 1 | Cache-disable bit from the page base control register |
| cr_cd | input | 1 | Global cache-disable control bit |
| cen_n | input | 1 | External cache enable, active low |
| rdy | input | 1 | Transfer ready strobe |
| fill_active | output | 1 | Current cycle is a line fill |
| xfer_idx | output | XFER_W (2) | Index of the next transfer in the fill |
| commit | output | 1 | One-clock pulse: write the line into the cache |
| discard | output | 1 | One-clock pulse: drop the filled line |
| pcd_out | output | 1 | Page-cache-disable output after masking |

## Verification
The hardest case to reach is the late enable sample. It must be isolated from the enable level in the final ready clock, and the two sit only one clock apart. The stimulus therefore puts a wait clock just before the last ready and drives opposite cen_n levels in those two clocks. It covers both orders, so a design that samples in the wrong clock reports the wrong verdict. A second hard case is a fill abandoned mid-line by a new cycle start. There the scoreboard queue holds no entry, and any stray pulse is flagged as unexpected.

// File: rtl/lfq_pkg.sv
package lfq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_st_e;

  typedef enum logic [1:0] {
    VERDICT_NONE    = 2'b00,
    VERDICT_COMMIT  = 2'b01,
    VERDICT_DISCARD = 2'b10
  } verdict_e;

endpackage

// File: rtl/lfq_rst_sync.sv
module lfq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lfq_xfer_ctr.sv
module lfq_xfer_ctr #(
  parameter int XFERS  = 4,
  parameter int XFER_W = $clog2(XFERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [XFER_W-1:0] idx,
  output logic              last
);

  localparam logic [XFER_W-1:0] LAST_IDX = XFER_W'(XFERS - 1);

  logic [XFER_W-1:0] cnt_q;
  logic [XFER_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = clr | adv;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign idx  = cnt_q;
  assign last = (cnt_q == LAST_IDX);

endmodule

// File: rtl/lfq_pcd_sel.sv
module lfq_pcd_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_paged,
  input  logic paging_en,
  input  logic pte_pcd,
  input  logic cr_pcd,
  input  logic cr_cd,
  output logic pcd_out
);

  logic pcd_q;
  logic pcd_d;
  logic use_pte;

  always_comb begin
    use_pte = paging_en & cyc_paged;
    pcd_d   = use_pte ? pte_pcd : cr_pcd;
    if (cr_cd) begin
      pcd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcd_q <= 1'b0;
    end else if (cyc_start) begin
      pcd_q <= pcd_d;
    end
  end

  assign pcd_out = pcd_q;

endmodule

// File: rtl/lfq_fill_ctl.sv
module lfq_fill_ctl
  import lfq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_read,
  input  logic cyc_cacheable,
  input  logic cyc_locked,
  input  logic cen_n,
  input  logic rdy,
  input  logic last,
  output logic fill_active,
  output logic ctr_clr,
  output logic ctr_adv,
  output logic commit,
  output logic discard
);

  fill_st_e st_q;
  fill_st_e st_d;
  logic     cen_prev_q;
  logic     commit_q;
  logic     commit_d;
  logic     discard_q;
  logic     discard_d;
  logic     want_fill;
  logic     in_fill;
  logic     last_beat;

  always_comb begin
    want_fill = cyc_read & cyc_cacheable & ~cyc_locked & ~cen_n;
    in_fill   = (st_q == ST_FILL);
    ctr_clr   = cyc_start;
    ctr_adv   = in_fill & rdy & ~cyc_start;
    last_beat = ctr_adv & last;

    st_d = st_q;
    if (cyc_start) begin
      st_d = want_fill ? ST_FILL : ST_IDLE;
    end else if (last_beat) begin
      st_d = ST_IDLE;
    end

    commit_d  = last_beat & ~cen_prev_q;
    discard_d = last_beat &  cen_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cen_prev_q <= 1'b1;
      commit_q   <= 1'b0;
      discard_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      cen_prev_q <= cen_n;
      commit_q   <= commit_d;
      discard_q  <= discard_d;
    end
  end

  assign fill_active = in_fill;
  assign commit      = commit_q;
  assign discard     = discard_q;

endmodule

// File: rtl/line_fill_qual.sv
module line_fill_qual #(
  parameter int LINE_BYTES = 16,
  parameter int BUS_BYTES  = 4,
  parameter int XFER_W     = $clog2(LINE_BYTES / BUS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_read,
  input  logic              cyc_cacheable,
  input  logic              cyc_locked,
  input  logic              cyc_paged,
  input  logic              paging_en,
  input  logic              pte_pcd,
  input  logic              cr_pcd,
  input  logic              cr_cd,
  input  logic              cen_n,
  input  logic              rdy,
  output logic              fill_active,
  output logic [XFER_W-1:0] xfer_idx,
  output logic              commit,
  output logic              discard,
  output logic              pcd_out
);

  localparam int XFERS = LINE_BYTES / BUS_BYTES;

  logic rst_sync_n;
  logic ctr_clr;
  logic ctr_adv;
  logic ctr_last;

  lfq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lfq_fill_ctl u_ctl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cyc_start     (cyc_start),
    .cyc_read      (cyc_read),
    .cyc_cacheable (cyc_cacheable),
    .cyc_locked    (cyc_locked),
    .cen_n         (cen_n),
    .rdy           (rdy),
    .last          (ctr_last),
    .fill_active   (fill_active),
    .ctr_clr       (ctr_clr),
    .ctr_adv       (ctr_adv),
    .commit        (commit),
    .discard       (discard)
  );

  lfq_xfer_ctr #(.XFERS(XFERS), .XFER_W(XFER_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (ctr_clr),
    .adv   (ctr_adv),
    .idx   (xfer_idx),
    .last  (ctr_last)
  );

  lfq_pcd_sel u_pcd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cyc_start (cyc_start),
    .cyc_paged (cyc_paged),
    .paging_en (paging_en),
    .pte_pcd   (pte_pcd),
    .cr_pcd    (cr_pcd),
    .cr_cd     (cr_cd),
    .pcd_out   (pcd_out)
  );

endmodule

// File: rtl/lfq_checker.sv
module lfq_checker #(
  parameter int XFER_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic              cyc_read,
  input logic              cyc_cacheable,
  input logic              cyc_locked,
  input logic              cr_cd,
  input logic              cen_n,
  input logic              rdy,
  input logic              fill_active,
  input logic [XFER_W-1:0] xfer_idx,
  input logic              commit,
  input logic              discard
);

  localparam logic [XFER_W-1:0] TOP_IDX = '1;

  AST_FILL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && cyc_read && cyc_cacheable && !cyc_locked && !cen_n) |=> fill_active); // R2

  AST_NO_FILL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && cen_n) |=> !fill_active); // R3

  AST_LOCKED_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && cyc_locked) |=> !fill_active); // R4

  AST_LAST_ENDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_active && rdy && !cyc_start && xfer_idx == TOP_IDX) |=> (!fill_active && (commit || discard))); // R6

  AST_COMMIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(cen_n, 2) == 1'b0)); // R7

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R7

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && discard)); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (xfer_idx == '0)); // R9

  AST_IDLE_RDY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_active && !cyc_start) |=> $stable(xfer_idx)); // R12

endmodule

bind line_fill_qual lfq_checker #(.XFER_W(XFER_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cyc_start     (cyc_start),
  .cyc_read      (cyc_read),
  .cyc_cacheable (cyc_cacheable),
  .cyc_locked    (cyc_locked),
  .cr_cd         (cr_cd),
  .cen_n         (cen_n),
  .rdy           (rdy),
  .fill_active   (fill_active),
  .xfer_idx      (xfer_idx),
  .commit        (commit),
  .discard       (discard)
);

// File: tb/tb_line_fill_qual.sv
`timescale 1ns/1ps
module tb_line_fill_qual;

  logic       clk;
  logic       rst_n;
  logic       cyc_start, cyc_read, cyc_cacheable, cyc_locked, cyc_paged;
  logic       paging_en, pte_pcd, cr_pcd, cr_cd, cen_n, rdy;
  logic       fill_active, commit, discard, pcd_out;
  logic [1:0] xfer_idx;

  int tests;
  int fails;
  bit done;

  typedef struct {
    logic [1:0] kind;   // 01 commit, 10 discard
    string      req;
  } exp_t;

  exp_t sb_q[$];

  line_fill_qual dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_read(cyc_read),
    .cyc_cacheable(cyc_cacheable), .cyc_locked(cyc_locked), .cyc_paged(cyc_paged),
    .paging_en(paging_en), .pte_pcd(pte_pcd), .cr_pcd(cr_pcd), .cr_cd(cr_cd),
    .cen_n(cen_n), .rdy(rdy), .fill_active(fill_active), .xfer_idx(xfer_idx),
    .commit(commit), .discard(discard), .pcd_out(pcd_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops scoreboard on each verdict pulse.
  always @(negedge clk) begin
    if (rst_n && !done && (commit || discard)) begin
      tests++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R9/R12 unexpected verdict actual=%b expected=none", {discard, commit});
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if ({discard, commit} !== e.kind) begin
          fails++;
          $display("FAIL %s verdict actual=%b expected=%b", e.req, {discard, commit}, e.kind);
        end
      end
    end
  end

  task automatic start_cycle(logic rd, logic cach, logic lck, logic en_n);
    cyc_start = 1'b1; cyc_read = rd; cyc_cacheable = cach; cyc_locked = lck; cen_n = en_n;
    tick();
    cyc_start = 1'b0; cen_n = 1'b1;
  endtask

  // Full fill: three readies, a wait clock with cen_pre, the last ready with cen_last.
  task automatic run_fill(logic cen_pre, logic cen_last, string req);
    exp_t e;
    start_cycle(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 fill entry", fill_active, 1);
    for (int i = 0; i < 3; i++) begin
      rdy = 1'b1; tick();
      chk("R5 index advance", xfer_idx, i + 1);
    end
    rdy = 1'b0; cen_n = cen_pre; tick();
    chk("R5 hold without ready", xfer_idx, 3);
    e.kind = cen_pre ? 2'b10 : 2'b01;
    e.req  = req;
    sb_q.push_back(e);
    rdy = 1'b1; cen_n = cen_last; tick();
    rdy = 1'b0; cen_n = 1'b1;
    chk("R6 fill ends", fill_active, 0);
    chk("R6 index wraps", xfer_idx, 0);
    tick();
    chk("R7 one-clock pulse", {discard, commit}, 0);
  endtask

  initial begin
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    cyc_start = 0; cyc_read = 0; cyc_cacheable = 0; cyc_locked = 0; cyc_paged = 0;
    paging_en = 0; pte_pcd = 0; cr_pcd = 0; cr_cd = 0; cen_n = 1; rdy = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 fill_active", fill_active, 0);
    chk("R1 verdict", {discard, commit}, 0);
    chk("R1 xfer_idx", xfer_idx, 0);
    chk("R1 pcd_out", pcd_out, 0);

    // R12: readies with no fill
    rdy = 1'b1; repeat (3) tick(); rdy = 1'b0;
    chk("R12 idle ready ignored", xfer_idx, 0);

    // R7: enable early, disabled in the final clock -> commit
    run_fill(1'b0, 1'b1, "R7 commit");
    // R8: enable inactive before, active in final clock -> discard
    run_fill(1'b1, 1'b0, "R8 discard");
    run_fill(1'b0, 1'b0, "R7 commit steady");
    run_fill(1'b1, 1'b1, "R8 discard steady");

    // R3: not a fill
    start_cycle(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R3 enable inactive", fill_active, 0);
    start_cycle(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3 uncacheable", fill_active, 0);
    start_cycle(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 write", fill_active, 0);
    rdy = 1'b1; repeat (5) tick(); rdy = 1'b0;
    chk("R12 ready after non-fill", xfer_idx, 0);

    // R4: locked
    start_cycle(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R4 locked no fill", fill_active, 0);
    rdy = 1'b1; repeat (4) tick(); rdy = 1'b0;
    chk("R4 locked no index", xfer_idx, 0);

    // R9: abandon mid-fill
    start_cycle(1'b1, 1'b1, 1'b0, 1'b0);
    rdy = 1'b1; repeat (2) tick(); rdy = 1'b0;
    chk("R9 mid-fill index", xfer_idx, 2);
    rdy = 1'b1;
    start_cycle(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 index cleared", xfer_idx, 0);
    chk("R9 fill abandoned", fill_active, 0);
    repeat (4) tick(); rdy = 1'b0;
    // R9: restart into a new fill that completes normally
    start_cycle(1'b1, 1'b1, 1'b0, 1'b0);
    rdy = 1'b1; tick();
    start_cycle(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R9 requalified fill", fill_active, 1);
    chk("R9 restart index", xfer_idx, 0);
    rdy = 1'b0;
    start_cycle(1'b0, 1'b0, 1'b0, 1'b1);

    // R10 / R11: page cache disable selection
    paging_en = 1; cyc_paged = 1; pte_pcd = 1; cr_pcd = 0; cr_cd = 0;
    start_cycle(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 paged uses entry bit", pcd_out, 1);
    pte_pcd = 0; tick();
    chk("R10 held between starts", pcd_out, 1);
    cyc_paged = 0; cr_pcd = 1; pte_pcd = 0;
    start_cycle(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 unpaged uses control bit", pcd_out, 1);
    paging_en = 0; cyc_paged = 1; pte_pcd = 0; cr_pcd = 0;
    start_cycle(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 paging off uses control bit", pcd_out, 0);
    paging_en = 1; pte_pcd = 1; cr_cd = 1;
    start_cycle(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R11 cache disable masks entry bit", pcd_out, 0);
    paging_en = 0; cr_pcd = 1;
    start_cycle(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R11 cache disable masks control bit", pcd_out, 0);
    cr_cd = 0;

    repeat (4) tick();
    chk("R7/R8 scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule